// File: doc/BRIEF.md
# Dual-Channel Configurable Edge Interrupt Detector

This block watches a set of external interrupt pins, two by default, that are not timed to the system clock. Each pin passes through its own synchronizer. A detector then compares two successive synchronized samples of that pin. When the transition it sees matches the channel's settings, the block raises a request on that channel for exactly one system clock cycle. Interrupt priority, vectoring and pending flags belong to a controller placed after this block.

Each channel has two configuration inputs. The first, `edge_any`, chooses between single-edge detection and detection on every transition. The second, `edge_fall`, is held in a separate configuration register. It sets the direction in single-edge mode: 0 means rising and 1 means falling. Both inputs can change at run time. A change of configuration never produces a request by itself, because detection always compares two real samples of the pin. During reset the detector history follows the synchronized pin level, so no edge is reported once reset is released.

Top module: `edge_irq_detector`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every `irq_req` bit is 0, even if a pin is held high through reset.
- R2: With `edge_any`=0 and `edge_fall`=0, a 0-to-1 transition of the pin gives one request, and a 1-to-0 transition gives none.
- R3: With `edge_any`=0 and `edge_fall`=1, a 1-to-0 transition of the pin gives one request, and a 0-to-1 transition gives none.
- R4: With `edge_any`=1, every transition of the pin gives one request, whatever the value of `edge_fall`.
- R5: A pin change that a rising clock edge samples first shows on `irq_req` after the third rising clock edge that follows. This uses the default two-stage synchronizer. The configuration in force is the one present just before that third edge.
- R6: Each qualifying transition gives a request exactly one clock cycle wide.
- R7: Channels are independent: a transition on one pin gives no request on any other channel.
- R8: A change of `edge_any` or `edge_fall` while the pin is steady gives no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | NUM_CH | Raw asynchronous interrupt pins, one bit per channel |
| edge_any | input | NUM_CH | 1: detect both edges; 0: single edge |
| edge_fall | input | NUM_CH | Direction in single-edge mode: 0 rising, 1 falling |
| irq_req | output | NUM_CH | One-cycle request pulse per channel |

## Verification
A request is due after the third rising clock edge that follows the first edge sampling the new pin level. The configuration that counts is the one sampled at that third edge. The bench records pin, configuration and reset values at every rising edge in its own shift registers. It compares `irq_req` on every falling edge against the pin values recorded two and three edges earlier and the configuration recorded at the latest edge, so each comparison falls half a cycle away from any edge where the output could change. Directed steps then count falling edges one by one after a pin change: zero at the first and second, one at the third, zero at the fourth.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    typedef enum logic [1:0] {
        DET_RISE = 2'd0,
        DET_FALL = 2'd1,
        DET_ANY  = 2'd2
    } det_kind_e;

    function automatic det_kind_e decode_kind(input logic any_edge, input logic fall_dir);
        if (any_edge)      return DET_ANY;
        else if (fall_dir) return DET_FALL;
        else               return DET_RISE;
    endfunction

    function automatic logic edge_hit(input det_kind_e kind, input logic now_lvl, input logic old_lvl);
        logic rise;
        logic fall;
        rise = now_lvl & ~old_lvl;
        fall = ~now_lvl & old_lvl;
        unique case (kind)
            DET_RISE: return rise;
            DET_FALL: return fall;
            DET_ANY:  return rise | fall;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d = st_q;
                st_d.chain[0] = async_in;
            end
        end else begin : g_multi
            always_comb begin
                st_d = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_out = st_q.chain[LAST];

endmodule

// File: rtl/edge_irq_chan.sv
module edge_irq_chan
    import edge_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_now,
    input  logic any_edge,
    input  logic fall_dir,
    output logic req
);
    typedef struct packed {
        logic hist;
        logic req;
    } chan_state_t;

    chan_state_t st_d, st_q;
    det_kind_e   kind;

    always_comb begin
        kind = decode_kind(any_edge, fall_dir);
        st_d = st_q;
        st_d.hist = lvl_now;
        if (!rst_n) begin
            st_d.req = 1'b0;
        end else begin
            st_d.req = edge_hit(kind, lvl_now, st_q.hist);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign req = st_q.req;

endmodule

// File: rtl/edge_irq_detector.sv
module edge_irq_detector #(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ext_pin,
    input  logic [NUM_CH-1:0] edge_any,
    input  logic [NUM_CH-1:0] edge_fall,
    output logic [NUM_CH-1:0] irq_req
);
    logic [NUM_CH-1:0] pin_sync;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            edge_irq_sync #(
                .STAGES(SYNC_STAGES)
            ) u_sync (
                .clk     (clk),
                .async_in(ext_pin[ch]),
                .sync_out(pin_sync[ch])
            );

            edge_irq_chan u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .lvl_now (pin_sync[ch]),
                .any_edge(edge_any[ch]),
                .fall_dir(edge_fall[ch]),
                .req     (irq_req[ch])
            );
        end
    endgenerate

endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ext_pin,
    input logic [NUM_CH-1:0] edge_any,
    input logic [NUM_CH-1:0] edge_fall,
    input logic [NUM_CH-1:0] irq_req
);
    logic [2:0] since_rst;
    logic       armed;

    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= 3'd0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    assign armed = rst_n && (since_rst >= 3'd5);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> irq_req == '0);

    generate
        if (SYNC_STAGES == 2) begin : g_timed
            for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
                // R2
                rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (armed && !$past(edge_any[ch]) && !$past(edge_fall[ch])
                     && $past(ext_pin[ch], 3) && !$past(ext_pin[ch], 4))
                    |-> irq_req[ch]);
                // R3
                falling_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (armed && !$past(edge_any[ch]) && $past(edge_fall[ch])
                     && !$past(ext_pin[ch], 3) && $past(ext_pin[ch], 4))
                    |-> irq_req[ch]);
                // R4
                any_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (armed && $past(edge_any[ch])
                     && ($past(ext_pin[ch], 3) != $past(ext_pin[ch], 4)))
                    |-> irq_req[ch]);
                // R8
                no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (armed && irq_req[ch])
                    |-> ($past(ext_pin[ch], 3) != $past(ext_pin[ch], 4)));
            end
        end
    endgenerate

endmodule

bind edge_irq_detector edge_irq_chk #(
    .NUM_CH     (NUM_CH),
    .SYNC_STAGES(SYNC_STAGES)
) u_edge_irq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_pin  (ext_pin),
    .edge_any (edge_any),
    .edge_fall(edge_fall),
    .irq_req  (irq_req)
);

// File: tb/test_edge_irq_detector.sv
module test_edge_irq_detector;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] ext_pin = '0;
    logic [NCH-1:0] edge_any = '0;
    logic [NCH-1:0] edge_fall = '0;
    logic [NCH-1:0] irq_req;

    int total = 0;
    int bad = 0;
    bit auto_on = 1'b0;

    always #4 clk = ~clk;

    edge_irq_detector #(.NUM_CH(NCH), .SYNC_STAGES(2)) i_edge_irq_detector (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin),
        .edge_any(edge_any), .edge_fall(edge_fall), .irq_req(irq_req)
    );

    logic [NCH-1:0] ph0, ph1, ph2, ph3, m_s, f_s;
    logic           r_s;

    always @(posedge clk) begin
        ph3 <= ph2; ph2 <= ph1; ph1 <= ph0; ph0 <= ext_pin;
        m_s <= edge_any; f_s <= edge_fall; r_s <= rst_n;
    end

    function automatic logic exp_bit(logic now_l, logic old_l, logic any_e, logic fall_d, logic rs);
        if (!rs) return 1'b0;
        if (any_e) return now_l != old_l;
        if (fall_d) return !now_l && old_l;
        return now_l && !old_l;
    endfunction

    task automatic check(string tag, logic act, logic expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (auto_on) begin
            for (int c = 0; c < NCH; c++) begin
                string tag;
                if (!r_s) tag = "R1";
                else if (ph2[c] == ph3[c]) tag = "R8";
                else if (m_s[c]) tag = "R4";
                else if (f_s[c]) tag = "R3";
                else tag = "R2";
                check(tag, irq_req[c], exp_bit(ph2[c], ph3[c], m_s[c], f_s[c], r_s));
            end
        end
    end

    task automatic step(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4021));
        // R1: pins high through reset, no request afterwards
        ext_pin = 2'b11;
        step(6);
        auto_on = 1'b1;
        check("R1", irq_req[0], 1'b0);
        rst_n = 1'b1;
        step(1);
        check("R1", irq_req[0] | irq_req[1], 1'b0);
        step(4);
        check("R1", irq_req[0] | irq_req[1], 1'b0);
        ext_pin = 2'b00;
        step(6);

        // R5, R6, R7: rising edge on channel 0, single-edge rising mode
        ext_pin[0] = 1'b1;
        step(1); check("R5", irq_req[0], 1'b0);
        step(1); check("R5", irq_req[0], 1'b0);
        step(1); check("R5", irq_req[0], 1'b1);
        check("R7", irq_req[1], 1'b0);
        step(1); check("R6", irq_req[0], 1'b0);
        step(3);

        // R2: falling edge ignored in rising mode
        ext_pin[0] = 1'b0;
        step(3); check("R2", irq_req[0], 1'b0);
        step(3);

        // R3: falling mode on channel 1
        edge_fall[1] = 1'b1;
        ext_pin[1] = 1'b1;
        step(3); check("R3", irq_req[1], 1'b0);
        step(2);
        ext_pin[1] = 1'b0;
        step(3); check("R3", irq_req[1], 1'b1);
        check("R7", irq_req[0], 1'b0);
        step(1); check("R6", irq_req[1], 1'b0);
        step(2);

        // R4: both edges, including back-to-back toggles
        edge_any = 2'b11;
        step(2);
        ext_pin[0] = 1'b1;
        step(1); ext_pin[0] = 1'b0;
        step(2); check("R4", irq_req[0], 1'b1);
        step(1); check("R4", irq_req[0], 1'b1);
        step(1); check("R6", irq_req[0], 1'b0);
        step(3);

        // R8: config toggles with steady pins
        ext_pin = 2'b01;
        step(5);
        for (int k = 0; k < 12; k++) begin
            edge_any = NCH'($urandom);
            edge_fall = NCH'($urandom);
            step(1);
            check("R8", irq_req[0] | irq_req[1], 1'b0);
        end

        // Random mix, checked by the per-cycle comparison
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 3) == 0) ext_pin[0] = ~ext_pin[0];
            if ($urandom_range(0, 4) == 0) ext_pin[1] = ~ext_pin[1];
            if ($urandom_range(0, 15) == 0) edge_any = NCH'($urandom);
            if ($urandom_range(0, 15) == 0) edge_fall = NCH'($urandom);
            if ($urandom_range(0, 499) == 0) begin
                rst_n = 1'b0;
                step(6);
                rst_n = 1'b1;
            end
            step(1);
        end

        step(4);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule